// File: doc/BRIEF.md
# I2C Master Primitive Engine

This block is the bus engine of an I2C master. Software directs it one primitive at a time. It writes a one-hot command word that asks for exactly one of five primitives: a Start condition, a Repeated Start condition, a Stop condition, the reception of one byte, or a single acknowledge bit. The engine runs the primitive on the bus and shows the pending command bit on `cmd_o` while it works. It clears that bit when the primitive ends, so software polls `cmd_o` or `busy_o` to learn when the next command may be given. A separate write of a byte to the transmit port sends eight data bits and then samples the slave's acknowledge bit.

The engine never sends an acknowledge bit on its own after a received byte. Software first stores the acknowledge value. It then issues an explicit acknowledge command, and the engine accepts that command only directly after a completed receive. Both bus lines are open-drain: the engine drives an output enable that pulls a line low and reads SDA back. Every bit period is split into four quarters of `QUARTER_CLKS` clock cycles each.

Top module: `i2c_prim_engine`

## Requirements
- R1: After reset `busy_o` is 0, `cmd_o` is 0, both line enables are 0 (lines released), `rx_data_o` is 0 and `slave_nack_o` is 0.
- R2: Command bit 0 (Start) makes SDA fall while SCL is high. It lasts 4 quarters and leaves both SCL and SDA pulled low.
- R3: Command bit 1 (Repeated Start) first releases SDA and then SCL, then makes SDA fall while SCL is high. It lasts 4 quarters and leaves both lines pulled low.
- R4: Command bit 2 (Stop) makes SDA rise while SCL is high. It lasts 4 quarters and leaves both lines released.
- R5: Command bit 3 (receive) keeps SDA released and clocks 8 bits in, MSB first. Each bit is sampled at the end of its second quarter, which is inside the SCL high phase. The byte appears on `rx_data_o` when the command ends, after 32 quarters, and no acknowledge bit is clocked.
- R6: Command bit 4 (acknowledge) clocks one bit carrying the stored acknowledge value and lasts 4 quarters. A value of 0 pulls SDA low (ACK) and a value of 1 leaves SDA released (NACK).
- R7: The acknowledge command is accepted only when the last completed primitive was a receive. Otherwise it is ignored, and it can be given at most once per received byte.
- R8: A command write is ignored while the engine is busy or when more than one command bit is set. A transmit write is ignored while the engine is busy or in the same cycle as a command write.
- R9: A transmit write sends 8 bits MSB first and then releases SDA for a ninth bit. The sampled ninth bit is stored in `slave_nack_o` (1 means NACK). The whole write lasts 36 quarters.
- R10: SDA changes while SCL is high only inside Start, Repeated Start and Stop. No data, receive or acknowledge bit creates a Start or Stop condition.
- R11: From the cycle after a command is accepted until it ends, `busy_o` is 1 and `cmd_o` shows only the accepted command bit. `cmd_o` returns to 0 when the command ends.
- R12: One quarter lasts exactly `QUARTER_CLKS` clock cycles, so `busy_o` stays high for 4·`QUARTER_CLKS` cycles for one bit period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_we_i | input | 1 | Command write strobe |
| cmd_i | input | 5 | One-hot command: 0 Start, 1 Repeated Start, 2 Stop, 3 receive, 4 acknowledge |
| ack_we_i | input | 1 | Write strobe for the stored acknowledge value |
| ack_val_i | input | 1 | Acknowledge value (1 = NACK, 0 = ACK) |
| tx_we_i | input | 1 | Transmit byte write strobe |
| tx_data_i | input | DATA_W | Byte to send |
| sda_i | input | 1 | Sampled SDA line |
| cmd_o | output | 5 | Pending command bit, cleared by hardware when the command ends |
| busy_o | output | 1 | A primitive or transmit is in progress |
| rx_data_o | output | DATA_W | Last received byte |
| slave_nack_o | output | 1 | Acknowledge bit sampled after the last transmit (1 = NACK) |
| scl_oe_o | output | 1 | Pulls SCL low when 1 |
| sda_oe_o | output | 1 | Pulls SDA low when 1 |

## Verification
The bench builds the block with `QUARTER_CLKS` = 3 and `DATA_W` = 8. With a quarter longer than one cycle, the one-cycle lag of the line registers sits strictly inside each quarter, so the sample point falls well within the SCL high phase. The short quarter keeps a 36-quarter transmit near a hundred cycles, so transmit, receive and every control primitive fit in one run. These values also make it possible to count exact busy lengths against the quarter arithmetic. A wired-AND slave model feeds bytes and acknowledge bits and counts Start and Stop events at the lines.

// File: rtl/i2c_prim_pkg.sv
package i2c_prim_pkg;
  localparam int CMD_W    = 5;
  localparam int C_START  = 0;
  localparam int C_RSTART = 1;
  localparam int C_STOP   = 2;
  localparam int C_RECV   = 3;
  localparam int C_ACK    = 4;

  typedef enum logic [2:0] {
    OP_IDLE, OP_START, OP_RSTART, OP_STOP, OP_RECV, OP_ACK, OP_SEND
  } op_e;

  typedef struct packed {
    logic scl_low;
    logic sda_low;
  } lines_t;
endpackage

// File: rtl/i2c_prim_qtick.sv
module i2c_prim_qtick #(
  parameter int unsigned QUARTER_CLKS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned CW = (QUARTER_CLKS > 1) ? $clog2(QUARTER_CLKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(QUARTER_CLKS - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (!run_i || tick_o) cnt_q <= '0;
    else cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/i2c_prim_shreg.sv
module i2c_prim_shreg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_data_i,
  input  logic         shift_i,
  input  logic         in_i,
  output logic [W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) data_o <= '0;
    else if (load_i) data_o <= load_data_i;
    else if (shift_i) data_o <= {data_o[W-2:0], in_i};
  end
endmodule

// File: rtl/i2c_prim_lines.sv
module i2c_prim_lines
  import i2c_prim_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  op_e        op_i,
  input  logic [1:0] phase_i,
  input  logic       data_bit_i,
  output logic       scl_oe_o,
  output logic       sda_oe_o
);
  lines_t nxt, cur_q;

  // quarter-phase waveforms; 1 = pull low
  always_comb begin
    nxt = cur_q;
    unique case (op_i)
      OP_START: begin
        nxt.scl_low = (phase_i == 2'd3);
        nxt.sda_low = (phase_i != 2'd0);
      end
      OP_RSTART: begin
        nxt.scl_low = (phase_i == 2'd0) || (phase_i == 2'd3);
        nxt.sda_low = phase_i[1];
      end
      OP_STOP: begin
        nxt.scl_low = (phase_i == 2'd0);
        nxt.sda_low = !phase_i[1];
      end
      OP_RECV, OP_ACK, OP_SEND: begin
        nxt.scl_low = (phase_i == 2'd0) || (phase_i == 2'd3);
        nxt.sda_low = !data_bit_i;
      end
      default: nxt = cur_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cur_q <= '0;
    else if (run_i) cur_q <= nxt;
  end

  assign scl_oe_o = cur_q.scl_low;
  assign sda_oe_o = cur_q.sda_low;
endmodule

// File: rtl/i2c_prim_engine.sv
module i2c_prim_engine
  import i2c_prim_pkg::*;
#(
  parameter int unsigned QUARTER_CLKS = 4,
  parameter int unsigned DATA_W       = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_we_i,
  input  logic [4:0]        cmd_i,
  input  logic              ack_we_i,
  input  logic              ack_val_i,
  input  logic              tx_we_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              sda_i,
  output logic [4:0]        cmd_o,
  output logic              busy_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              slave_nack_o,
  output logic              scl_oe_o,
  output logic              sda_oe_o
);
  localparam int unsigned BIT_W = $clog2(DATA_W + 1);
  localparam logic [BIT_W-1:0] LAST_SEND = BIT_W'(DATA_W);
  localparam logic [BIT_W-1:0] LAST_RECV = BIT_W'(DATA_W - 1);

  op_e               op_q, cmd_op;
  logic [1:0]        phase_q;
  logic [BIT_W-1:0]  bit_q, last_idx;
  logic              samp_q, rx_last_q, ack_q, nack_q;
  logic [DATA_W-1:0] rx_q, sh_data;
  logic              tick, end_bit, is_last, shift_en;
  logic              cmd_ok, tx_ok, data_bit;

  assign busy_o = (op_q != OP_IDLE);

  always_comb begin
    unique case (cmd_i)
      5'b00001: cmd_op = OP_START;
      5'b00010: cmd_op = OP_RSTART;
      5'b00100: cmd_op = OP_STOP;
      5'b01000: cmd_op = OP_RECV;
      5'b10000: cmd_op = OP_ACK;
      default:  cmd_op = OP_IDLE;
    endcase
  end

  // acknowledge only legal right after a completed receive
  assign cmd_ok = cmd_we_i && !busy_o && (cmd_op != OP_IDLE) &&
                  ((cmd_op != OP_ACK) || rx_last_q);
  assign tx_ok  = tx_we_i && !cmd_we_i && !busy_o;

  always_comb begin
    cmd_o = '0;
    unique case (op_q)
      OP_START:  cmd_o[C_START]  = 1'b1;
      OP_RSTART: cmd_o[C_RSTART] = 1'b1;
      OP_STOP:   cmd_o[C_STOP]   = 1'b1;
      OP_RECV:   cmd_o[C_RECV]   = 1'b1;
      OP_ACK:    cmd_o[C_ACK]    = 1'b1;
      default:   cmd_o = '0;
    endcase
  end

  always_comb begin
    unique case (op_q)
      OP_SEND: last_idx = LAST_SEND;
      OP_RECV: last_idx = LAST_RECV;
      default: last_idx = '0;
    endcase
  end

  assign end_bit  = tick && (phase_q == 2'd3);
  assign is_last  = (bit_q == last_idx);
  assign shift_en = end_bit && ((op_q == OP_SEND) || (op_q == OP_RECV)) &&
                    (bit_q < LAST_SEND);

  always_comb begin
    unique case (op_q)
      OP_SEND: data_bit = (bit_q < LAST_SEND) ? sh_data[DATA_W-1] : 1'b1;
      OP_ACK:  data_bit = ack_q;
      default: data_bit = 1'b1;
    endcase
  end

  i2c_prim_qtick #(.QUARTER_CLKS(QUARTER_CLKS)) u_qtick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (busy_o),
    .tick_o(tick)
  );

  i2c_prim_shreg #(.W(DATA_W)) u_shreg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tx_ok),
    .load_data_i(tx_data_i),
    .shift_i    (shift_en),
    .in_i       (samp_q),
    .data_o     (sh_data)
  );

  i2c_prim_lines u_lines (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (busy_o),
    .op_i      (op_q),
    .phase_i   (phase_q),
    .data_bit_i(data_bit),
    .scl_oe_o  (scl_oe_o),
    .sda_oe_o  (sda_oe_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ack_q <= 1'b0;
    else if (ack_we_i) ack_q <= ack_val_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q      <= OP_IDLE;
      phase_q   <= '0;
      bit_q     <= '0;
      samp_q    <= 1'b0;
      rx_last_q <= 1'b0;
      nack_q    <= 1'b0;
      rx_q      <= '0;
    end else if (cmd_ok || tx_ok) begin
      op_q      <= cmd_ok ? cmd_op : OP_SEND;
      phase_q   <= '0;
      bit_q     <= '0;
      rx_last_q <= 1'b0;
    end else if (tick) begin
      phase_q <= phase_q + 2'd1;
      if (phase_q == 2'd1) samp_q <= sda_i;  // mid SCL high
      if (end_bit) begin
        if (is_last) begin
          op_q <= OP_IDLE;
          if (op_q == OP_RECV) begin
            rx_q      <= {sh_data[DATA_W-2:0], samp_q};
            rx_last_q <= 1'b1;
          end
          if (op_q == OP_SEND) nack_q <= samp_q;
        end else begin
          bit_q <= bit_q + BIT_W'(1);
        end
      end
    end
  end

  assign rx_data_o    = rx_q;
  assign slave_nack_o = nack_q;
endmodule

// File: rtl/i2c_prim_engine_chk.sv
module i2c_prim_engine_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cmd_we_i,
  input logic [4:0] cmd_i,
  input logic [4:0] cmd_o,
  input logic       busy_o,
  input logic       scl_oe_o,
  input logic       sda_oe_o
);
  assert_cmd_onehot_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cmd_o));

  assert_start_taken_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && !busy_o && cmd_i == 5'b00001) |=> (busy_o && cmd_o == 5'b00001));

  assert_busy_write_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cmd_we_i) |=> ((cmd_o == $past(cmd_o)) || (cmd_o == 5'b00000)));

  assert_sda_high_scl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(scl_oe_o) && !scl_oe_o && (sda_oe_o != $past(sda_oe_o)))
      |-> ($past(cmd_o[2:0]) != 3'b000));

  assert_start_end_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy_o) && $past(cmd_o[0])) |-> (scl_oe_o && sda_oe_o));

  assert_stop_end_free_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy_o) && $past(cmd_o[2])) |-> (!scl_oe_o && !sda_oe_o));
endmodule

bind i2c_prim_engine i2c_prim_engine_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cmd_we_i(cmd_we_i),
  .cmd_i   (cmd_i),
  .cmd_o   (cmd_o),
  .busy_o  (busy_o),
  .scl_oe_o(scl_oe_o),
  .sda_oe_o(sda_oe_o)
);

// File: tb/i2c_prim_engine_bench.sv
module i2c_prim_engine_bench;
  localparam int QC = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic cmd_we, ack_we, ack_val, tx_we;
  logic [4:0] cmd_in;
  logic [7:0] tx_data;
  logic [4:0] cmd_o;
  logic busy, nack, scl_oe, sda_oe;
  logic [7:0] rx_data;
  logic sl_pull, sda_line, scl_line;

  int n_chk = 0, n_err = 0;
  int sl_mode = 0, sl_rises = 0, sl_falls = 0;
  int n_start = 0, n_stop = 0;
  logic [7:0] sl_byte, sl_cap;
  logic sl_ack, sda_at_rise, prev_scl, prev_sda;

  always #5 clk = ~clk;

  assign sda_line = ~(sda_oe | sl_pull);
  assign scl_line = ~scl_oe;

  i2c_prim_engine #(.QUARTER_CLKS(QC), .DATA_W(8)) u_i2c_prim_engine (
    .clk_i(clk), .rst_ni(rst_n), .cmd_we_i(cmd_we), .cmd_i(cmd_in),
    .ack_we_i(ack_we), .ack_val_i(ack_val), .tx_we_i(tx_we), .tx_data_i(tx_data),
    .sda_i(sda_line), .cmd_o(cmd_o), .busy_o(busy), .rx_data_o(rx_data),
    .slave_nack_o(nack), .scl_oe_o(scl_oe), .sda_oe_o(sda_oe)
  );

  // slave model and line monitor
  always @(negedge clk) begin
    if (scl_line && !prev_scl) begin
      if (sl_mode == 2 && sl_rises < 8) sl_cap = {sl_cap[6:0], sda_line};
      sl_rises++;
      sda_at_rise = sda_line;
    end
    if (!scl_line && prev_scl) begin
      sl_falls++;
      if (sl_mode == 1) sl_pull = (sl_falls < 8) ? ~sl_byte[7-sl_falls] : 1'b0;
      else if (sl_mode == 2) sl_pull = (sl_falls == 8) && sl_ack;
      else sl_pull = 1'b0;
    end
    if (scl_line && prev_scl && (sda_line != prev_sda)) begin
      if (!sda_line) n_start++;
      else n_stop++;
    end
    prev_scl = scl_line;
    prev_sda = sda_line;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  task automatic slave_setup(input int mode, input logic [7:0] b, input logic a);
    sl_mode = mode; sl_byte = b; sl_ack = a;
    sl_rises = 0; sl_falls = 0; sl_cap = '0;
    sl_pull = (mode == 1) ? ~b[7] : 1'b0;
  endtask

  task automatic do_cmd(input logic [4:0] c);
    @(negedge clk); cmd_we = 1'b1; cmd_in = c;
    @(negedge clk); cmd_we = 1'b0; cmd_in = '0;
  endtask

  task automatic do_tx(input logic [7:0] b);
    @(negedge clk); tx_we = 1'b1; tx_data = b;
    @(negedge clk); tx_we = 1'b0;
  endtask

  task automatic set_ack(input logic v);
    @(negedge clk); ack_we = 1'b1; ack_val = v;
    @(negedge clk); ack_we = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 5000) begin n++; @(negedge clk); end
  endtask

  // {is_rx, byte, slave_ack}
  localparam logic [9:0] VEC [0:5] = '{
    {1'b0, 8'hA5, 1'b1}, {1'b0, 8'h3C, 1'b0}, {1'b1, 8'h96, 1'b0},
    {1'b1, 8'h01, 1'b0}, {1'b0, 8'hFF, 1'b1}, {1'b1, 8'h80, 1'b0}
  };

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    int n, s0, p0;
    rst_n = 1'b0; cmd_we = 0; cmd_in = '0; ack_we = 0; ack_val = 0;
    tx_we = 0; tx_data = '0; sl_pull = 0; sl_byte = '0; sl_cap = '0; sl_ack = 0;
    sda_at_rise = 1; prev_scl = 1; prev_sda = 1;
    repeat (3) @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 cmd", cmd_o, 0);
    chk("R1 lines", {scl_oe, sda_oe}, 0);
    chk("R1 rx/nack", {rx_data, nack}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 start
    do_cmd(5'b00001);
    chk("R11 cmd shown", {busy, cmd_o}, 6'b100001);
    wait_idle(n);
    chk("R12 start length", n, 4*QC);
    chk("R2 start seen", n_start, 1);
    chk("R2 lines low", {scl_oe, sda_oe}, 2'b11);
    chk("R11 cmd cleared", cmd_o, 0);

    // R7 ack not after receive, R8 multi-bit
    set_ack(1'b0);
    do_cmd(5'b10000);
    chk("R7 ack ignored", {busy, cmd_o}, 0);
    do_cmd(5'b00011);
    chk("R8 multi-bit ignored", {busy, cmd_o}, 0);

    for (int i = 0; i < 6; i++) begin
      s0 = n_start; p0 = n_stop;
      if (VEC[i][9]) begin
        slave_setup(1, VEC[i][8:1], 1'b0);
        do_cmd(5'b01000);
        wait_idle(n);
        chk("R5 rx byte", rx_data, VEC[i][8:1]);
        chk("R5 rx length", n, 32*QC);
      end else begin
        slave_setup(2, VEC[i][8:1], VEC[i][0]);
        do_tx(VEC[i][8:1]);
        wait_idle(n);
        chk("R9 tx byte", sl_cap, VEC[i][8:1]);
        chk("R9 slave nack", nack, !VEC[i][0]);
        chk("R9 tx length", n, 36*QC);
      end
      chk("R10 no start/stop", {n_start - s0, n_stop - p0}, 0);
    end
    slave_setup(0, 8'h00, 1'b0);

    // R8 writes while busy
    p0 = n_stop;
    slave_setup(2, 8'h3C, 1'b1);
    do_tx(8'h3C);
    do_cmd(5'b00100);
    do_tx(8'hC3);
    wait_idle(n);
    chk("R8 stop ignored", n_stop, p0);
    chk("R8 tx ignored", sl_cap, 8'h3C);
    chk("R8 scl held low", scl_oe, 1);
    slave_setup(0, 8'h00, 1'b0);

    // R6 ACK after receive
    slave_setup(1, 8'h5A, 1'b0);
    do_cmd(5'b01000);
    wait_idle(n);
    slave_setup(0, 8'h00, 1'b0);
    set_ack(1'b0);
    do_cmd(5'b10000);
    chk("R6 ack taken", {busy, cmd_o}, 6'b110000);
    wait_idle(n);
    chk("R6 ack length", n, 4*QC);
    chk("R6 ack low", sda_at_rise, 0);
    do_cmd(5'b10000);
    chk("R7 second ack ignored", busy, 0);

    // R6 NACK after receive
    slave_setup(1, 8'hC3, 1'b0);
    do_cmd(5'b01000);
    wait_idle(n);
    slave_setup(0, 8'h00, 1'b0);
    set_ack(1'b1);
    do_cmd(5'b10000);
    wait_idle(n);
    chk("R6 nack high", sda_at_rise, 1);

    // R3 repeated start
    s0 = n_start;
    do_cmd(5'b00010);
    wait_idle(n);
    chk("R3 restart seen", n_start - s0, 1);
    chk("R3 lines low", {scl_oe, sda_oe}, 2'b11);

    // R4 stop
    p0 = n_stop;
    do_cmd(5'b00100);
    wait_idle(n);
    chk("R4 stop seen", n_stop - p0, 1);
    chk("R4 lines free", {scl_oe, sda_oe}, 0);
    chk("R4 stop length", n, 4*QC);

    summary();
    $finish;
  end
endmodule